// File: doc/BRIEF.md
# Repeater Port Partition Controller

This block guards the twisted-pair ports of a 100 Mbps repeater against ports that keep colliding. For every port it follows the transmit, receive and collision indications, sampled only in cycles where a shared bit-time strobe is high. It isolates a port that breaks the collision rules and reconnects it once a clean run of traffic shows the link has recovered. Each port has two inputs from its register block: an enable and a rule select.

With the rule select low (normal rule), only clean traffic sent to the port by the repeater counts toward recovery. With it high (alternate rule, the register default), clean traffic in either direction counts. The alternate rule also isolates a port after one long collision. A partitioned port is still watched so that it can recover, but its active gate is low, so its traffic is not forwarded.

A manager-present strap is sampled during reset. With the strap high, ports start enabled. With it low, every port stays disabled until software has written its enable low and then high again.

Top module: `rptr_partition_ctrl`

## Requirements
- R1: With `mgr_present_i` high during reset, and from the second cycle after reset, every port with `port_en_i` high has `part_o`=0 and `active_o`=1.
- R2: With `mgr_present_i` low during reset, a port has `active_o`=0 even with `port_en_i` held high. It becomes active only after its `port_en_i` has been seen low and then high.
- R3: An event is a run of strobes with any of transmit, receive or collision high, ended by a strobe with all three low. A connected port partitions when CCOL_LIMIT consecutive events contain a collision. An event without a collision clears the count.
- R4: Under the alternate rule (`alt_sel_i`=1), a connected port partitions on the (LONG_COL_BITS+1)th consecutive strobe with collision high. Under the normal rule, a collision strobe never partitions a connected port.
- R5: Under the normal rule, a partitioned port reconnects on the UNPART_BITS-th consecutive strobe with transmit high and collision low. Receive-only traffic never reconnects it.
- R6: Under the alternate rule, a partitioned port reconnects on the UNPART_BITS-th consecutive strobe with transmit or receive high and collision low.
- R7: A collision strobe, or a strobe with no qualifying traffic, restarts the clean-run count of a partitioned port.
- R8: Driving `port_en_i` low forces `active_o` low on the next cycle. Within two cycles `part_o` clears, and all counters and event tracking are reset. When the enable returns, the port restarts connected.
- R9: Partition state changes only on cycles with `bit_stb_i` high, unless the port is being disabled.
- R10: `active_o` is high exactly when the port is enabled and not partitioned. Partitioned ports keep following their traffic so that they can recover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mgr_present_i | input | 1 | Manager-present strap, sampled while reset is high |
| bit_stb_i | input | 1 | Bit-time strobe qualifying all line inputs |
| port_en_i | input | NPORTS | Per-port enable from the register block |
| alt_sel_i | input | NPORTS | Per-port recovery rule: 0 normal, 1 alternate |
| tx_act_i | input | NPORTS | Repeater transmitting to the port |
| rx_act_i | input | NPORTS | Port receiving |
| col_i | input | NPORTS | Collision seen on the port |
| part_o | output | NPORTS | Port partitioned |
| active_o | output | NPORTS | Port forwarding gate |

## Verification
The assertions assume that the line inputs only matter on strobe cycles. They also assume that `alt_sel_i` is a steady configuration level, not a signal that toggles inside a run of traffic. The stimulus changes the rule select only between tests, while each port is idle. Line inputs are driven on the falling edge, once per strobe period, and the strobe is high for one cycle out of two. The bench uses small limits so that every threshold can be swept just below and exactly at its value.

// File: rtl/rptr_part_pkg.sv
package rptr_part_pkg;

    typedef enum logic {
        PS_CONNECTED = 1'b0,
        PS_ISOLATED  = 1'b1
    } port_state_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic col;
    } line_obs_t;

    // Any line activity on the port in this strobe.
    function automatic logic line_busy(line_obs_t o);
        return o.tx | o.rx | o.col;
    endfunction

    // Strobe counts toward recovery under the selected rule.
    function automatic logic recover_qualifies(logic alt, line_obs_t o);
        return !o.col && (o.tx || (alt && o.rx));
    endfunction

endpackage

// File: rtl/part_sat_counter.sv
module part_sat_counter #(
    parameter int unsigned MAX_VAL = 8,
    parameter int unsigned W       = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)
            cnt_q <= '0;
        else if (inc_i && (cnt_q != W'(MAX_VAL)))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == W'(MAX_VAL) && !clr_i) |=> (cnt_q == W'(MAX_VAL)));
endmodule

// File: rtl/part_enable_gate.sv
module part_enable_gate #(
    parameter int unsigned NPORTS = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strap_i,
    input  logic [NPORTS-1:0] en_req_i,
    output logic [NPORTS-1:0] en_o
);
    logic [NPORTS-1:0] armed_q;
    logic [NPORTS-1:0] en_q;

    for (genvar g = 0; g < NPORTS; g++) begin : g_gate
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                armed_q[g] <= strap_i;
                en_q[g]    <= 1'b0;
            end else begin
                if (!en_req_i[g])
                    armed_q[g] <= 1'b1;
                en_q[g] <= en_req_i[g] & armed_q[g];
            end
        end

        p_strap_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            !armed_q[g] |=> !en_q[g]);
    end

    assign en_o = en_q;
endmodule

// File: rtl/part_port_fsm.sv
module part_port_fsm
    import rptr_part_pkg::*;
#(
    parameter int unsigned UNPART_BITS   = 512,
    parameter int unsigned CCOL_LIMIT    = 64,
    parameter int unsigned LONG_COL_BITS = 1024
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      bt_i,
    input  logic      en_i,
    input  logic      alt_i,
    input  line_obs_t obs_i,
    output logic      part_o
);
    localparam int unsigned CLEAN_W = $clog2(UNPART_BITS + 1);
    localparam int unsigned CCOL_W  = $clog2(CCOL_LIMIT + 1);
    localparam int unsigned LONG_W  = $clog2(LONG_COL_BITS + 2);

    port_state_e state_q;
    logic        evt_q, evt_col_q;
    logic        step, busy, evt_end, conn, iso, qual;
    logic        long_hit, ccol_hit, go_iso, recover;
    logic [CLEAN_W-1:0] clean_cnt;
    logic [CCOL_W-1:0]  ccol_cnt;
    logic [LONG_W-1:0]  colrun_cnt;
    logic clean_clr, clean_inc, ccol_clr, ccol_inc, run_clr, run_inc;

    always_comb begin
        step     = bt_i & en_i;
        busy     = line_busy(obs_i);
        conn     = (state_q == PS_CONNECTED);
        iso      = (state_q == PS_ISOLATED);
        qual     = recover_qualifies(alt_i, obs_i);
        evt_end  = step & evt_q & !busy;
        long_hit = step & conn & alt_i & obs_i.col
                   & (colrun_cnt == LONG_W'(LONG_COL_BITS));
        ccol_hit = evt_end & evt_col_q & conn
                   & (ccol_cnt == CCOL_W'(CCOL_LIMIT - 1));
        go_iso   = long_hit | ccol_hit;
        recover  = step & iso & qual
                   & (clean_cnt == CLEAN_W'(UNPART_BITS - 1));

        run_clr   = !en_i | (bt_i & !obs_i.col);
        run_inc   = step & obs_i.col;
        ccol_clr  = !en_i | go_iso | recover | (evt_end & !evt_col_q);
        ccol_inc  = evt_end & evt_col_q & conn;
        clean_clr = !en_i | recover | (step & (!iso | !qual));
        clean_inc = step & iso & qual;
    end

    part_sat_counter #(.MAX_VAL(LONG_COL_BITS + 1), .W(LONG_W)) u_colrun (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(run_clr), .inc_i(run_inc),
        .cnt_o(colrun_cnt));

    part_sat_counter #(.MAX_VAL(CCOL_LIMIT), .W(CCOL_W)) u_ccol (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(ccol_clr), .inc_i(ccol_inc),
        .cnt_o(ccol_cnt));

    part_sat_counter #(.MAX_VAL(UNPART_BITS), .W(CLEAN_W)) u_clean (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(clean_clr), .inc_i(clean_inc),
        .cnt_o(clean_cnt));

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            state_q   <= PS_CONNECTED;
            evt_q     <= 1'b0;
            evt_col_q <= 1'b0;
        end else if (step) begin
            if (busy) begin
                evt_q     <= 1'b1;
                evt_col_q <= evt_col_q | obs_i.col;
            end else begin
                evt_q     <= 1'b0;
                evt_col_q <= 1'b0;
            end
            if (go_iso)
                state_q <= PS_ISOLATED;
            else if (recover)
                state_q <= PS_CONNECTED;
        end
    end

    assign part_o = iso;

    p_quiet_cycles_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bt_i && en_i) |=> $stable(state_q));

    p_disable_clears_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (state_q == PS_CONNECTED));

    p_rx_no_recover_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (bt_i && en_i && !alt_i && iso && !obs_i.tx) |=> (state_q == PS_ISOLATED));

    p_normal_col_stays_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (bt_i && en_i && !alt_i && conn && obs_i.col) |=> (state_q == PS_CONNECTED));
endmodule

// File: rtl/rptr_partition_ctrl.sv
module rptr_partition_ctrl
    import rptr_part_pkg::*;
#(
    parameter int unsigned NPORTS        = 8,
    parameter int unsigned UNPART_BITS   = 512,
    parameter int unsigned CCOL_LIMIT    = 64,
    parameter int unsigned LONG_COL_BITS = 1024
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mgr_present_i,
    input  logic              bit_stb_i,
    input  logic [NPORTS-1:0] port_en_i,
    input  logic [NPORTS-1:0] alt_sel_i,
    input  logic [NPORTS-1:0] tx_act_i,
    input  logic [NPORTS-1:0] rx_act_i,
    input  logic [NPORTS-1:0] col_i,
    output logic [NPORTS-1:0] part_o,
    output logic [NPORTS-1:0] active_o
);
    logic [NPORTS-1:0] en_eff;

    part_enable_gate #(.NPORTS(NPORTS)) u_gate (
        .clk_i(clk_i), .rst_i(rst_i), .strap_i(mgr_present_i),
        .en_req_i(port_en_i), .en_o(en_eff));

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        line_obs_t obs;
        assign obs = '{tx: tx_act_i[g], rx: rx_act_i[g], col: col_i[g]};

        part_port_fsm #(
            .UNPART_BITS(UNPART_BITS),
            .CCOL_LIMIT(CCOL_LIMIT),
            .LONG_COL_BITS(LONG_COL_BITS)
        ) u_fsm (
            .clk_i(clk_i), .rst_i(rst_i), .bt_i(bit_stb_i), .en_i(en_eff[g]),
            .alt_i(alt_sel_i[g]), .obs_i(obs), .part_o(part_o[g]));

        assign active_o[g] = en_eff[g] & !part_o[g];

        p_active_needs_enable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
            active_o[g] |-> $past(port_en_i[g]));
    end
endmodule

// File: tb/rptr_partition_ctrl_tb_top.sv
`timescale 1ns/1ps
module rptr_partition_ctrl_tb_top;
    localparam int NP = 2;
    localparam int UL = 8;
    localparam int CL = 4;
    localparam int LL = 6;

    logic clk = 1'b0;
    logic rst, strap, bt;
    logic [NP-1:0] en, alt, tx, rx, col, part, act;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rptr_partition_ctrl #(.NPORTS(NP), .UNPART_BITS(UL), .CCOL_LIMIT(CL),
                          .LONG_COL_BITS(LL)) dut_i (
        .clk_i(clk), .rst_i(rst), .mgr_present_i(strap), .bit_stb_i(bt),
        .port_en_i(en), .alt_sel_i(alt), .tx_act_i(tx), .rx_act_i(rx),
        .col_i(col), .part_o(part), .active_o(act));

    task automatic chk(string req, logic [NP-1:0] actual, logic [NP-1:0] expv);
        checks++;
        if (actual !== expv) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, actual, expv);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // One strobe period on port 0; port 1 idle.
    task automatic step(logic t, logic r, logic c);
        tx = {1'b0, t}; rx = {1'b0, r}; col = {1'b0, c}; bt = 1'b1;
        @(negedge clk);
        bt = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(int n, logic t, logic r, logic c);
        for (int k = 0; k < n; k++) step(t, r, c);
    endtask

    task automatic do_reset(logic s);
        strap = s; rst = 1'b1; bt = 1'b0; tx = '0; rx = '0; col = '0;
        cyc(3);
        rst = 1'b0;
        cyc(2);
    endtask

    task automatic bounce0();
        en[0] = 1'b0; cyc(3); en[0] = 1'b1; cyc(3);
    endtask

    initial begin
        en = '1; alt = '1;
        do_reset(1'b1);
        chk("R1 part after reset", part, 2'b00);
        chk("R1 active after reset", act, 2'b11);

        // R9: collision without strobes changes nothing
        col = 2'b01; cyc(20); col = '0; cyc(1);
        chk("R9 no strobe no partition", part, 2'b00);

        // R4 alternate: LL strobes of collision not enough, LL+1 partitions
        run(LL, 0, 0, 1); step(0, 0, 0);
        chk("R4 alt long col below limit", part, 2'b00);
        run(LL + 1, 0, 0, 1);
        chk("R4 alt long col partitions", part, 2'b01);
        chk("R10 active gated", act, 2'b10);
        step(0, 0, 0);

        // R6/R7 alternate recovery on receive
        run(UL - 1, 0, 1, 0);
        chk("R6 rx run one short", part, 2'b01);
        step(0, 0, 0);
        run(4, 0, 1, 0); step(0, 1, 1); run(UL - 1, 0, 1, 0);
        chk("R7 collision restarts run", part, 2'b01);
        step(0, 1, 0);
        chk("R6 rx run reconnects", part, 2'b00);
        chk("R10 active restored", act, 2'b11);
        bounce0();

        // R8 disable clears partition
        run(LL + 1, 0, 0, 1);
        chk("R8 partitioned before disable", part, 2'b01);
        en[0] = 1'b0; cyc(1);
        chk("R8 active drops", act, 2'b10);
        cyc(1);
        chk("R8 part cleared", part, 2'b00);
        en[0] = 1'b1; cyc(2);
        chk("R8 restart connected", act, 2'b11);
        chk("R8 restart part", part, 2'b00);

        // R3 consecutive collisions, normal rule
        alt[0] = 1'b0;
        for (int k = 0; k < CL - 1; k++) begin step(1, 0, 1); step(0, 0, 0); end
        chk("R3 below limit", part, 2'b00);
        step(1, 0, 0); step(0, 0, 0);
        for (int k = 0; k < CL - 1; k++) begin step(1, 0, 1); step(0, 0, 0); end
        chk("R3 clean event cleared count", part, 2'b00);
        step(1, 0, 1); step(0, 0, 0);
        chk("R3 limit partitions", part, 2'b01);

        // R5 normal recovery only on transmit
        run(3 * UL, 0, 1, 0); step(0, 0, 0);
        chk("R5 rx does not reconnect", part, 2'b01);
        run(UL - 1, 1, 0, 0);
        chk("R5 tx run one short", part, 2'b01);
        step(1, 0, 0);
        chk("R5 tx run reconnects", part, 2'b00);
        step(0, 0, 0);
        bounce0();

        // R4 normal: long collision does not partition
        run(LL + 4, 0, 0, 1);
        chk("R4 normal long col stays", part, 2'b00);
        step(0, 0, 0);

        // R1/R2 strap low
        do_reset(1'b0);
        chk("R2 strap low inactive", act, 2'b00);
        chk("R2 strap low part", part, 2'b00);
        cyc(5);
        chk("R2 enable held high no effect", act, 2'b00);
        en[0] = 1'b0; cyc(2); en[0] = 1'b1; cyc(3);
        chk("R2 rewrite enables port", act, 2'b01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule